// File: doc/BRIEF.md
# Whole-Register Vector Load/Store Sequencer

This block turns one whole-register vector memory command into a run of memory beats. A command gives the number of registers in the group, the first register of the group, a direction (load or store), a memory element-width hint and a base byte address. The block checks that the group size is one of the legal powers of two and that the first register is aligned to that size. It then emits one request per beat at ascending addresses. Together the beats cover the group size times VLEN/8 bytes. Each beat is tagged with the destination or source register and with the byte offset inside that register.

The group size comes from the command itself, not from any configured grouping. The amount of data moved depends only on the group size and VLEN. The width hint never changes the transfer. On a load the hint is passed along with each beat so that the register file can choose a layout. On a store no hint is passed. A command that fails the checks raises a one-cycle illegal flag and produces no beats. The memory system and the register file sit outside the block.

Top module: `vecWholeRegSeq`

## Requirements
- R1: After reset, startReady is 1, and reqValid, done and illegal are all 0.
- R2: The legal group sizes (cmdCount) are 1, 2, 4 and 8. For any other value (0, 3, 5, 6, 7, 9 to 15), illegal is 1 in the cycle after the command is accepted, and reqValid stays 0.
- R3: A command whose cmdReg is not a multiple of cmdCount is illegal in the same way. For example, register 4 with group size 8 is illegal and register 0 is legal.
- R4: A legal command produces exactly cmdCount * VLEN / (8 * BEAT_BYTES) accepted beats, whatever the width hint is.
- R5: Beat i carries reqAddr = cmdBase + i * BEAT_BYTES. The first beat is presented in the cycle after the command is accepted.
- R6: Beat i carries reqReg = cmdReg + i / beatsPerReg and reqOffset = (i mod beatsPerReg) * BEAT_BYTES, where beatsPerReg = VLEN / (8 * BEAT_BYTES).
- R7: A beat advances only on a cycle with reqValid and reqReady both high. While reqReady is low, every request output holds its value.
- R8: On loads (cmdIsStore = 0), reqHintValid is 1 and reqHint equals cmdWidthHint. On stores, reqHintValid is 0 and reqHint is 0.
- R9: reqLast is 1 only on the final beat. done is 1 for exactly the one cycle after the final beat is accepted. In that cycle reqValid is 0 and startReady is 1.
- R10: While a command is running, startReady is 0, and startValid together with the command inputs has no effect on the beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Command present |
| startReady | output | 1 | Block idle; command accepted when both are high |
| cmdIsStore | input | 1 | 1 = store, 0 = load |
| cmdCount | input | CNT_W | Number of registers in the group |
| cmdReg | input | REG_W | First register of the group |
| cmdWidthHint | input | HINT_W | Element-width layout hint |
| cmdBase | input | ADDR_W | Base byte address |
| reqValid | output | 1 | Beat request present |
| reqReady | input | 1 | Memory accepts the beat |
| reqAddr | output | ADDR_W | Beat byte address |
| reqIsStore | output | 1 | Direction of the beat |
| reqReg | output | REG_W | Register the beat belongs to |
| reqOffset | output | OFS_W | Byte offset inside that register |
| reqHintValid | output | 1 | Hint present (loads only) |
| reqHint | output | HINT_W | Width hint |
| reqLast | output | 1 | Final beat of the command |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-command pulse |

## Verification
The assertions assume that reqReady is the only thing that moves a running beat stream forward. They also assume that the memory side never needs a beat to be withdrawn. The bench meets both assumptions: it drives reqReady only at falling edges, and it changes the command inputs only at falling edges. When the bench drives startValid while a command is running, it keeps reqReady low in that cycle, so the command-side poke and a beat advance never fall on the same edge. Random commands draw group sizes and registers from their whole encoding ranges, so both legal and illegal encodings appear. Every run drains to done before the next command starts.

// File: rtl/wrsPkg.sv
package wrsPkg;
  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic load;     // capture the command and clear the beat index
    logic advance;  // the current beat was accepted
  } wrsStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wrsState_e;
endpackage

// File: rtl/wrsCtrl.sv
module wrsCtrl
  import wrsPkg::*;
#(
  parameter int REG_W = 5,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic [REG_W-1:0] cmdReg,
  input  logic             reqReady,
  input  logic             lastBeat,
  output logic             startReady,
  output logic             reqValid,
  output logic             done,
  output logic             illegal,
  output wrsStrobe_t       strobe
);
  wrsState_e state;
  logic sizeOk;
  logic alignOk;
  logic cmdLegal;
  logic [REG_W-1:0] alignMask;

  // Group size must be one of the legal powers of two
  always_comb begin
    case (cmdCount)
      CNT_W'(1), CNT_W'(2), CNT_W'(4), CNT_W'(8): sizeOk = 1'b1;
      default:                                     sizeOk = 1'b0;
    endcase
  end

  // The first register must be aligned to the group size
  assign alignMask = REG_W'(cmdCount) - REG_W'(1);
  assign alignOk   = (cmdReg & alignMask) == '0;
  assign cmdLegal  = sizeOk && alignOk;

  assign startReady     = (state == ST_IDLE);
  assign reqValid       = (state == ST_RUN);
  assign strobe.load    = startReady && startValid && cmdLegal;
  assign strobe.advance = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startValid) begin
            if (cmdLegal) state <= ST_RUN;
            else          illegal <= 1'b1;
          end
        end
        ST_RUN: begin
          if (reqReady && lastBeat) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wrsDatapath.sv
module wrsDatapath
  import wrsPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REG_W      = 5,
  parameter int CNT_W      = 4,
  parameter int HINT_W     = 2,
  parameter int VLEN       = 128,
  parameter int BEAT_BYTES = 8,
  localparam int REG_BYTES = VLEN / 8,
  localparam int BPR       = REG_BYTES / BEAT_BYTES,
  localparam int BPR_LOG   = $clog2(BPR),
  localparam int BEAT_LOG  = $clog2(BEAT_BYTES),
  localparam int OFS_W     = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1,
  localparam int BEAT_W    = $clog2((1 << CNT_W) * BPR) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrsStrobe_t        strobe,
  input  logic              cmdIsStore,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [REG_W-1:0]  cmdReg,
  input  logic [HINT_W-1:0] cmdWidthHint,
  input  logic [ADDR_W-1:0] cmdBase,
  output logic              lastBeat,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqIsStore,
  output logic [REG_W-1:0]  reqReg,
  output logic [OFS_W-1:0]  reqOffset,
  output logic              reqHintValid,
  output logic [HINT_W-1:0] reqHint
);
  logic [ADDR_W-1:0] baseAddr;
  logic [REG_W-1:0]  baseReg;
  logic              isStore;
  logic [HINT_W-1:0] hint;
  logic [BEAT_W-1:0] totalBeats;
  logic [BEAT_W-1:0] beatIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr   <= '0;
      baseReg    <= '0;
      isStore    <= 1'b0;
      hint       <= '0;
      totalBeats <= '0;
      beatIdx    <= '0;
    end else if (strobe.load) begin
      baseAddr   <= cmdBase;
      baseReg    <= cmdReg;
      isStore    <= cmdIsStore;
      hint       <= cmdWidthHint;
      // Length depends only on the group size and VLEN
      totalBeats <= BEAT_W'(cmdCount) << BPR_LOG;
      beatIdx    <= '0;
    end else if (strobe.advance) begin
      beatIdx <= beatIdx + BEAT_W'(1);
    end
  end

  assign lastBeat     = (beatIdx == totalBeats - BEAT_W'(1));
  assign reqAddr      = baseAddr + (ADDR_W'(beatIdx) << BEAT_LOG);
  assign reqReg       = baseReg + REG_W'(beatIdx >> BPR_LOG);
  assign reqIsStore   = isStore;
  assign reqHintValid = !isStore;
  assign reqHint      = isStore ? '0 : hint;

  generate
    if (BPR_LOG == 0) begin : gOneBeatPerReg
      assign reqOffset = '0;
    end else begin : gMultiBeatPerReg
      assign reqOffset = OFS_W'(beatIdx[BPR_LOG-1:0]) << BEAT_LOG;
    end
  endgenerate
endmodule

// File: rtl/vecWholeRegSeq.sv
module vecWholeRegSeq
  import wrsPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REG_W      = 5,
  parameter int CNT_W      = 4,
  parameter int HINT_W     = 2,
  parameter int VLEN       = 128,
  parameter int BEAT_BYTES = 8,
  localparam int REG_BYTES = VLEN / 8,
  localparam int OFS_W     = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  output logic              startReady,
  input  logic              cmdIsStore,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [REG_W-1:0]  cmdReg,
  input  logic [HINT_W-1:0] cmdWidthHint,
  input  logic [ADDR_W-1:0] cmdBase,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqIsStore,
  output logic [REG_W-1:0]  reqReg,
  output logic [OFS_W-1:0]  reqOffset,
  output logic              reqHintValid,
  output logic [HINT_W-1:0] reqHint,
  output logic              reqLast,
  output logic              done,
  output logic              illegal
);
  wrsStrobe_t strobe;
  logic lastBeat;

  wrsCtrl #(.REG_W(REG_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .cmdCount(cmdCount),
    .cmdReg(cmdReg), .reqReady(reqReady), .lastBeat(lastBeat),
    .startReady(startReady), .reqValid(reqValid), .done(done),
    .illegal(illegal), .strobe(strobe)
  );

  wrsDatapath #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W), .HINT_W(HINT_W),
    .VLEN(VLEN), .BEAT_BYTES(BEAT_BYTES)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdIsStore(cmdIsStore),
    .cmdCount(cmdCount), .cmdReg(cmdReg), .cmdWidthHint(cmdWidthHint),
    .cmdBase(cmdBase), .lastBeat(lastBeat), .reqAddr(reqAddr),
    .reqIsStore(reqIsStore), .reqReg(reqReg), .reqOffset(reqOffset),
    .reqHintValid(reqHintValid), .reqHint(reqHint)
  );

  assign reqLast = reqValid && lastBeat;
endmodule

// File: rtl/wrsChecker.sv
module wrsChecker #(
  parameter int ADDR_W     = 32,
  parameter int REG_W      = 5,
  parameter int HINT_W     = 2,
  parameter int OFS_W      = 4,
  parameter int BEAT_BYTES = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReady,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqIsStore,
  input logic [REG_W-1:0]  reqReg,
  input logic [OFS_W-1:0]  reqOffset,
  input logic              reqHintValid,
  input logic [HINT_W-1:0] reqHint,
  input logic              reqLast,
  input logic              done,
  input logic              illegal
);
  p_illegal_no_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !reqValid);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqLast) |=>
      (reqValid && reqAddr == $past(reqAddr) + ADDR_W'(BEAT_BYTES)));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=>
      (reqValid && $stable(reqAddr) && $stable(reqReg) && $stable(reqOffset)
       && $stable(reqLast) && $stable(reqIsStore)));

  p_store_no_hint_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsStore) |-> (!reqHintValid && reqHint == '0));

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLast) |=> (done && !reqValid && startReady));

  p_pulses_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, illegal, reqValid}));

  p_busy_blocks_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !startReady);
endmodule

bind vecWholeRegSeq wrsChecker #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .HINT_W(HINT_W), .OFS_W(OFS_W),
  .BEAT_BYTES(BEAT_BYTES)
) uChk (
  .clk(clk), .rstN(rstN), .startReady(startReady), .reqValid(reqValid),
  .reqReady(reqReady), .reqAddr(reqAddr), .reqIsStore(reqIsStore),
  .reqReg(reqReg), .reqOffset(reqOffset), .reqHintValid(reqHintValid),
  .reqHint(reqHint), .reqLast(reqLast), .done(done), .illegal(illegal)
);

// File: tb/vecWholeRegSeq_test.sv
module vecWholeRegSeq_test;
  localparam int VLEN = 128;
  localparam int BEAT_BYTES = 8;
  localparam int BPR = VLEN / 8 / BEAT_BYTES;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic startReady;
  logic cmdIsStore = 1'b0;
  logic [3:0] cmdCount = '0;
  logic [4:0] cmdReg = '0;
  logic [1:0] cmdWidthHint = '0;
  logic [31:0] cmdBase = '0;
  logic reqValid;
  logic reqReady = 1'b0;
  logic [31:0] reqAddr;
  logic reqIsStore;
  logic [4:0] reqReg;
  logic [3:0] reqOffset;
  logic reqHintValid;
  logic [1:0] reqHint;
  logic reqLast;
  logic done;
  logic illegal;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vecWholeRegSeq uut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .cmdIsStore(cmdIsStore), .cmdCount(cmdCount), .cmdReg(cmdReg),
    .cmdWidthHint(cmdWidthHint), .cmdBase(cmdBase), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqIsStore(reqIsStore),
    .reqReg(reqReg), .reqOffset(reqOffset), .reqHintValid(reqHintValid),
    .reqHint(reqHint), .reqLast(reqLast), .done(done), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit legalModel(input logic [3:0] cnt, input logic [4:0] rg);
    if (!(cnt == 1 || cnt == 2 || cnt == 4 || cnt == 8)) return 1'b0;
    return (int'(rg) % int'(cnt)) == 0;
  endfunction

  task automatic runCmd(input logic st, input logic [3:0] cnt, input logic [4:0] rg,
                        input logic [1:0] hn, input logic [31:0] base,
                        input bit poke, input int readyPct);
    int total;
    int k;
    bit poked;
    @(negedge clk);
    chk(startReady == 1'b1, "R9", "idle before command", startReady, 1);
    startValid = 1'b1; cmdIsStore = st; cmdCount = cnt; cmdReg = rg;
    cmdWidthHint = hn; cmdBase = base;
    @(negedge clk);
    startValid = 1'b0;
    if (!legalModel(cnt, rg)) begin
      if (cnt == 1 || cnt == 2 || cnt == 4 || cnt == 8)
        chk(illegal == 1'b1 && reqValid == 1'b0, "R3", "misaligned flagged",
            {illegal, reqValid}, 2);
      else
        chk(illegal == 1'b1 && reqValid == 1'b0, "R2", "bad size flagged",
            {illegal, reqValid}, 2);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(reqValid == 1'b0 && illegal == 1'b0, "R2", "no beats after illegal",
            {illegal, reqValid}, 0);
      end
      return;
    end
    total = int'(cnt) * BPR;
    k = 0;
    poked = 1'b0;
    while (k < total) begin
      chk(reqValid == 1'b1, "R7", "valid held until all beats", reqValid, 1);
      if (poke && !poked) begin
        poked = 1'b1;
        chk(startReady == 1'b0, "R10", "busy blocks start", startReady, 0);
        startValid = 1'b1; cmdCount = 4'd1; cmdReg = 5'd7; cmdBase = 32'hdead0000;
        cmdIsStore = ~st; cmdWidthHint = ~hn;
        reqReady = 1'b0;
        @(negedge clk);
        startValid = 1'b0;
        continue;
      end
      reqReady = (($urandom % 100) < readyPct);
      if (reqReady) begin
        chk(reqAddr == base + 32'(k * BEAT_BYTES), "R5", "beat address",
            reqAddr, base + 32'(k * BEAT_BYTES));
        chk(reqReg == 5'(int'(rg) + k / BPR), "R6", "beat register",
            reqReg, 5'(int'(rg) + k / BPR));
        chk(reqOffset == 4'((k % BPR) * BEAT_BYTES), "R6", "beat offset",
            reqOffset, (k % BPR) * BEAT_BYTES);
        chk(reqIsStore == st && reqHintValid == !st && reqHint == (st ? 2'd0 : hn),
            "R8", "hint on loads only", {reqIsStore, reqHintValid, reqHint},
            {st, !st, (st ? 2'd0 : hn)});
        chk(reqLast == (k == total - 1), "R9", "last flag", reqLast, k == total - 1);
        k++;
      end
      @(negedge clk);
    end
    reqReady = 1'b0;
    chk(done == 1'b1 && reqValid == 1'b0 && startReady == 1'b1, "R4",
        "beat count ends the run", {done, reqValid, startReady}, 5);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done is one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    chk(startReady == 1'b1 && reqValid == 1'b0 && done == 1'b0 && illegal == 1'b0,
        "R1", "reset state", {startReady, reqValid, done, illegal}, 8);
    rstN = 1'b1;
    @(negedge clk);
    chk(startReady == 1'b1 && reqValid == 1'b0, "R1", "after reset",
        {startReady, reqValid}, 2);
    // Directed corners
    runCmd(1'b0, 4'd8, 5'd0,  2'd3, 32'h0000_1000, 1'b0, 100);
    runCmd(1'b0, 4'd8, 5'd4,  2'd0, 32'h0000_2000, 1'b0, 100); // R3
    runCmd(1'b1, 4'd2, 5'd3,  2'd1, 32'h0000_3000, 1'b0, 100); // R3
    runCmd(1'b0, 4'd3, 5'd0,  2'd1, 32'h0000_4000, 1'b0, 100); // R2
    runCmd(1'b0, 4'd0, 5'd0,  2'd1, 32'h0000_4000, 1'b0, 100); // R2
    runCmd(1'b0, 4'd4, 5'd28, 2'd0, 32'hffff_fff0, 1'b0, 50);
    runCmd(1'b1, 4'd1, 5'd31, 2'd2, 32'h0000_5008, 1'b0, 30);
    runCmd(1'b0, 4'd2, 5'd6,  2'd0, 32'h0000_6000, 1'b0, 70);  // R4 hint 0
    runCmd(1'b0, 4'd2, 5'd6,  2'd3, 32'h0000_6000, 1'b0, 70);  // R4 hint 3
    runCmd(1'b1, 4'd4, 5'd8,  2'd1, 32'h0000_7000, 1'b1, 60);  // R10 poke
    runCmd(1'b0, 4'd1, 5'd9,  2'd2, 32'h0000_7100, 1'b1, 60);  // R10 poke
    // Constrained random
    for (int n = 0; n < 60; n++) begin
      logic [3:0] c;
      logic [4:0] r;
      c = 4'($urandom % 16);
      r = 5'($urandom % 32);
      if (($urandom % 2) == 0 && (c == 2 || c == 4 || c == 8))
        r = r & ~5'(c - 1);
      runCmd(1'($urandom % 2), c, r, 2'($urandom % 4), $urandom,
             ($urandom % 4) == 0, 20 + int'($urandom % 81));
    end
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule